// File: doc/BRIEF.md
# Tick Interrupt Pending/Ack Arbiter

This block sits between a periodic timer and an interrupt controller. Every timer tick adds to a saturating count of ticks not yet serviced, so ticks that arrive while an earlier interrupt is still outstanding are kept rather than lost. An acknowledge from the interrupt controller removes one tick from that count and re-arms the delivery path.

Delivery is paced by the consumer. When it pulses the inject-request strobe, the block emits a one-cycle interrupt pulse, but only if at least one tick is pending and the previous pulse has been acknowledged. Reprogramming the timer, signalled on the reload input, discards all pending ticks and re-arms delivery. This has the same effect as reset.

Top module: `tick_irq_arbiter`

## Requirements
- R1: After synchronous reset, `irq_o` and `pending_nz_o` are 0 and delivery is armed, so the first request after a tick produces a pulse.
- R2: A tick with no acknowledge in the same cycle raises the pending count by one; `pending_nz_o` is 1 whenever the count is nonzero.
- R3: The pending count is `CNT_W` bits wide (default 8) and saturates at its maximum (255) instead of wrapping; 300 ticks followed by 255 acknowledges leave it at zero.
- R4: An acknowledge with no tick in the same cycle lowers the count by one but never below zero, and it arms delivery.
- R5: A tick and an acknowledge in the same cycle leave the count unchanged.
- R6: A request produces a pulse only when the pending count is nonzero and delivery is armed.
- R7: A pulse disarms delivery, so no further pulse is issued until an acknowledge arrives.
- R8: `irq_o` is high for exactly one clock cycle per injection, in the cycle after the accepted request.
- R9: A reload clears the count and arms delivery, and it suppresses any request in the same cycle.
- R10: When a request is accepted in the same cycle as an acknowledge, the injection wins and delivery ends the cycle disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timer tick |
| ack_i | input | 1 | Interrupt acknowledge from the controller |
| reload_i | input | 1 | Timer was reprogrammed; flush pending ticks |
| inject_req_i | input | 1 | Request to deliver a pending tick |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pending_nz_o | output | 1 | Pending count is nonzero |

## Verification
The assertions check several properties on every cycle. The count holds at its maximum when a tick arrives, it stays at zero under acknowledge alone, and it is zero after a reload. No pulse follows a cycle with an empty count or disarmed delivery, and every pulse lasts one cycle. The bench scenarios check the rest. Saturation is shown by counting acknowledges back down from 300 ticks. The directed cases also cover the net-zero tick-with-acknowledge case, a request colliding with an acknowledge, and a reload colliding with a request. In each case the effect is observed only at the two outputs.

// File: rtl/tia_pkg.sv
package tia_pkg;
  localparam int DEF_CNT_W = 8;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/pend_counter.sv
module pend_counter
  import tia_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_op_e op;

  always_comb begin
    if (clr_i)                op = CNT_CLR;
    else if (tick_i && !ack_i) op = CNT_INC;
    else if (ack_i && !tick_i) op = CNT_DEC;
    else                      op = CNT_HOLD;
  end

  always_comb begin
    unique case (op)
      CNT_CLR: cnt_d = '0;
      CNT_INC: cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      CNT_DEC: cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign nz_o = (cnt_q != '0);

  // R3: a full count stays full under a lone tick
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && tick_i && !ack_i && !clr_i) |=> (cnt_q == CNT_MAX));

  // R4: an empty count never goes below zero
  a_r4_floor: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !tick_i) |=> (cnt_q == '0));

  // R9: reload empties the count
  a_r9_reload_clears: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/inject_gate.sv
module inject_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ack_i,
  input  logic reload_i,
  input  logic pend_nz_i,
  output logic irq_o
);
  logic acked_q, irq_q, fire;

  assign fire = req_i && pend_nz_i && acked_q && !reload_i;

  always_ff @(posedge clk) begin
    if (rst || reload_i) begin
      acked_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)       acked_q <= 1'b0;
      else if (ack_i) acked_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R7: no pulse while delivery is disarmed
  a_r7_wait_ack: assert property (@(posedge clk) disable iff (rst)
    !acked_q |=> !irq_q);

  // R9: reload re-arms and blocks a pulse
  a_r9_reload_arms: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (acked_q && !irq_q));
endmodule

// File: rtl/tick_irq_arbiter.sv
module tick_irq_arbiter
  import tia_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ack_i,
  input  logic reload_i,
  input  logic inject_req_i,
  output logic irq_o,
  output logic pending_nz_o
);
  logic cnt_nz;

  pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .ack_i  (ack_i),
    .clr_i  (reload_i),
    .nz_o   (cnt_nz)
  );

  inject_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .req_i     (inject_req_i),
    .ack_i     (ack_i),
    .reload_i  (reload_i),
    .pend_nz_i (cnt_nz),
    .irq_o     (irq_o)
  );

  assign pending_nz_o = cnt_nz;

  // R6: an empty count cannot lead to a pulse
  a_r6_needs_pending: assert property (@(posedge clk) disable iff (rst)
    !cnt_nz |=> !irq_o);

  // R8: every pulse lasts a single cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: tb/tb_tick_irq_arbiter.sv
module tb_tick_irq_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, ack_i = 1'b0, reload_i = 1'b0, inject_req_i = 1'b0;
  logic irq_o, pending_nz_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tick_irq_arbiter dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ack_i(ack_i),
    .reload_i(reload_i), .inject_req_i(inject_req_i),
    .irq_o(irq_o), .pending_nz_o(pending_nz_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs; outputs reflect that cycle on return
  task automatic step(input logic t, input logic a, input logic r, input logic q);
    tick_i = t; ack_i = a; reload_i = r; inject_req_i = q;
    @(negedge clk);
    tick_i = 0; ack_i = 0; reload_i = 0; inject_req_i = 0;
  endtask

  task automatic t_reset;
    chk(irq_o, 1'b0, "R1 irq after reset");
    chk(pending_nz_o, 1'b0, "R1 pending after reset");
  endtask

  task automatic t_basic;
    step(1, 0, 0, 0); chk(pending_nz_o, 1'b1, "R2 tick raises pending");
    step(0, 0, 0, 1); chk(irq_o, 1'b1, "R1 R6 first request pulses");
    step(0, 0, 0, 0); chk(irq_o, 1'b0, "R8 pulse one cycle");
    step(0, 0, 0, 1); chk(irq_o, 1'b0, "R7 no pulse before ack");
    step(0, 1, 0, 0); chk(pending_nz_o, 1'b0, "R4 ack decrements");
    step(0, 0, 0, 1); chk(irq_o, 1'b0, "R6 no pulse on empty count");
  endtask

  task automatic t_floor;
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    chk(pending_nz_o, 1'b0, "R4 ack at zero stays zero");
    step(1, 0, 0, 0); chk(pending_nz_o, 1'b1, "R4 one tick after floor");
    step(0, 1, 0, 0); chk(pending_nz_o, 1'b0, "R4 no underflow memory");
  endtask

  task automatic t_both;
    step(1, 1, 0, 0); chk(pending_nz_o, 1'b0, "R5 tick+ack at zero");
    step(1, 0, 0, 0);
    step(1, 1, 0, 0); chk(pending_nz_o, 1'b1, "R5 tick+ack holds one");
    step(0, 1, 0, 0); chk(pending_nz_o, 1'b0, "R5 count was exactly one");
  endtask

  task automatic t_sat;
    step(0, 0, 1, 0);
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 254; i++) step(0, 1, 0, 0);
    chk(pending_nz_o, 1'b1, "R3 still pending after 254 acks");
    step(0, 1, 0, 0);
    chk(pending_nz_o, 1'b0, "R3 saturated at 255");
  endtask

  task automatic t_reload;
    step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 0, 0, 1); chk(irq_o, 1'b1, "R6 pulse with pending");
    step(0, 0, 1, 1);
    chk(irq_o, 1'b0, "R9 reload blocks request");
    chk(pending_nz_o, 1'b0, "R9 reload clears count");
    step(1, 0, 0, 0);
    step(0, 0, 0, 1); chk(irq_o, 1'b1, "R9 reload re-arms");
  endtask

  task automatic t_collide;
    step(0, 1, 0, 0); chk(pending_nz_o, 1'b0, "R4 ack empties count");
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 1, 0, 1); chk(irq_o, 1'b1, "R10 request with ack pulses");
    chk(pending_nz_o, 1'b1, "R10 one tick left");
    step(0, 0, 0, 1); chk(irq_o, 1'b0, "R10 injection wins, disarmed");
    step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1); chk(irq_o, 1'b1, "R7 ack re-arms delivery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_floor();
    t_both();
    t_sat();
    t_reload();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule